// File: doc/BRIEF.md
# Serial BCH(15,7) Systematic Encoder

This block turns a 7-bit message into a 15-bit codeword of the binary double-error-correcting BCH(15,7) code. The generator is the degree-8 product of the two GF(16) minimal polynomials 1+x+x^4 and 1+x+x^2+x^3+x^4. This product is g(x) = 1+x^4+x^6+x^7+x^8, which gives a minimum distance of at least 5. The encoder is systematic. The codeword is the message multiplied by x^8, plus the remainder of that product divided by g(x).

A request loads the message into a shift register in one cycle. The message then enters a division LFSR one bit per clock, highest coefficient first. Once the seventh bit is in, feedback is switched off and the eight parity bits are shifted out behind the message. The output register collects all fifteen bits serially. A full encode takes exactly 15 clocks after the start is accepted. A one-cycle done pulse then marks the finished codeword, which stays on the output until the next accepted start.

Top module: `bch15_7_enc`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `codeword` is all zeros.
- R2: `start` sampled high while `busy` is 0 is accepted. `busy` is 1 from the next cycle, and a start issued in the cycle that shows `done` is also accepted.
- R3: `done` rises exactly 15 clock edges after the edge that accepted `start`, and stays high for one cycle only. `busy` falls on that same edge and is high in each of the 14 cycles between.
- R4: At `done`, bits 14..8 of `codeword` equal the accepted message, with message bit 6 at codeword bit 14.
- R5: At `done`, bits 7..0 of `codeword` equal the remainder of m(x)*x^8 divided by g(x) = x^8+x^7+x^6+x^4+1. Codeword bit i is the coefficient of x^i.
- R6: Every codeword produced at `done` is divisible by g(x) with no remainder. This holds for all 128 messages.
- R7: `start` while `busy` is 1 is ignored. It changes neither the timing of `done` nor the codeword of the encode in progress.
- R8: `codeword` holds its value from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Encode request, sampled when idle |
| msg | input | 7 | Message, bit 6 is the highest coefficient |
| busy | output | 1 | Encode in progress |
| done | output | 1 | One-cycle pulse, codeword valid |
| codeword | output | 15 | Message in bits 14..8, parity in bits 7..0 |

## Verification
The bench builds the encoder with its default parameters: length 15, message width 7 and the degree-8 generator. At this size the whole message space of 128 words can be covered exhaustively. Each result is compared with a long-division model, and the cycle at which `done` appears is checked on every run. Random messages then arrive with back-to-back starts and with spurious starts in the middle of an encode, to exercise the ignore rule and the hold behaviour.

// File: rtl/bch15_7_enc.sv
module bch15_7_enc #(
  parameter int N   = 15,
  parameter int K   = 7,
  parameter logic [N-K:0] GEN = 9'h1D1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] msg,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] codeword
);
  localparam int P  = N - K;
  localparam int CW = $clog2(N + 1);

  logic [K-1:0]  msg_sr;
  logic [P-1:0]  par;
  logic [CW-1:0] cnt;
  logic          in_msg, out_bit, fb;

  assign in_msg  = (cnt < CW'(K));
  assign fb      = in_msg & (msg_sr[K-1] ^ par[P-1]);
  assign out_bit = in_msg ? msg_sr[K-1] : par[P-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      codeword <= '0;
      msg_sr   <= '0;
      par      <= '0;
      cnt      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          msg_sr <= msg;
          par    <= '0;
          cnt    <= '0;
        end
      end else begin
        codeword <= {codeword[N-2:0], out_bit};
        msg_sr   <= {msg_sr[K-2:0], 1'b0};
        par      <= {par[P-2:0], 1'b0} ^ (fb ? GEN[P-1:0] : '0);
        cnt      <= cnt + 1'b1;
        if (cnt == CW'(N - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bch15_7_enc_chk.sv
module bch15_7_enc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [6:0]  msg,
  input logic        busy,
  input logic        done,
  input logic [14:0] codeword
);
  logic [3:0] run_cnt;
  logic [6:0] held_msg;

  function automatic logic [7:0] rem15(input logic [14:0] v);
    logic [14:0] r;
    r = v;
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'h1D1 << (i - 8));
    return r[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      held_msg <= '0;
    end else if (start && !busy) begin
      run_cnt  <= 4'd1;
      held_msg <= msg;
    end else if (run_cnt != 0) begin
      run_cnt <= (run_cnt == 4'd15) ? 4'd0 : run_cnt + 4'd1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 4'd15) |=> (done && !busy));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt != 0) |-> busy);
  assert_msg_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (codeword[14:8] == held_msg));
  assert_divisible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem15(codeword) == 8'h00));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(codeword));
endmodule

bind bch15_7_enc bch15_7_enc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
  .busy(busy), .done(done), .codeword(codeword)
);

// File: tb/bch15_7_enc_tb_top.sv
module bch15_7_enc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  msg = '0;
  logic        busy, done;
  logic [14:0] codeword;
  int checks = 0, fails = 0;
  int unsigned seed = 32'h5eed_1234;

  always #4 clk = ~clk;

  bch15_7_enc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
    .busy(busy), .done(done), .codeword(codeword)
  );

  function automatic logic [7:0] parity_of(input logic [6:0] m);
    logic [14:0] r;
    r = {m, 8'h00};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'b1_1101_0001 << (i - 8));
    return r[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // junk_at: cycle (1..14) to raise a spurious start, 0 = none
  task automatic encode(input logic [6:0] m, input int junk_at, input bit back2back);
    logic [14:0] exp_cw;
    exp_cw = {m, parity_of(m)};
    if (!back2back) @(negedge clk);
    start = 1'b1;
    msg = m;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 15; k++) begin
      if (k < 15) begin
        chk(busy && !done, "R3 busy-window", {busy, done}, 2'b10);
        if (k == junk_at) begin
          start = 1'b1;
          msg = ~m;
        end else start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !busy, "R3 done-timing", {busy, done}, 2'b01);
    chk(codeword[14:8] == m, "R4 message-field", codeword[14:8], m);
    chk(codeword[7:0] == exp_cw[7:0], junk_at != 0 ? "R7 parity-after-junk" : "R5 parity", codeword[7:0], exp_cw[7:0]);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [14:0] held;
    repeat (3) @(negedge clk);
    chk(!busy && !done && codeword == 0, "R1 reset", {busy, done, codeword}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: exhaustive sweep of all messages
    for (int m = 0; m < 128; m++) encode(7'(m), 0, 1'b0);

    // R8: hold after done
    held = codeword;
    repeat (5) @(negedge clk);
    chk(codeword == held && !done, "R8 hold", codeword, held);

    // R2: back-to-back start issued in the done cycle
    encode(7'h7F, 0, 1'b0);
    encode(7'h01, 0, 1'b1);
    encode(7'h40, 0, 1'b1);

    // R7: spurious starts mid-encode, random messages
    for (int i = 0; i < 64; i++) begin
      logic [6:0] rm;
      int j;
      rm = 7'($urandom(seed + i));
      j = 1 + int'($urandom() % 14);
      encode(rm, j, (i % 3) == 0);
    end

    @(negedge clk);
    chk(!busy && !done, "R7 idle-after-junk", {busy, done}, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule